// File: doc/BRIEF.md
# Radix-2^2 Delay-Feedback Butterfly Pair

This block is the front of a streaming pipelined FFT. It takes one complex sample per enabled clock (signed real and imaginary parts, 16 bits each by default) and passes it through two butterfly stages in a single-path delay-feedback arrangement. The first stage pairs each sample with the one N/2 positions later in the same frame. The second stage pairs samples N/4 apart inside every N/2-long group that the first stage emits. A general twiddle multiplier can follow the pair and take its output stream directly, with no reordering in between.

Each stage keeps a feedback memory as deep as its butterfly span. During the first half of its period the stage stores fresh inputs and emits the differences it kept from the previous period. During the second half it emits sums and keeps the new differences for later. The second stage multiplies by -j the inputs that need it. It does this by exchanging the real and imaginary parts and negating one of them, so the pair needs no multiplier. Every add and subtract is halved by an arithmetic shift, so the word width stays the same from stage to stage.

Top module: `r22_sdf_pair`

## Requirements
- R1: A synchronous active-high reset clears both sample counters, both feedback memories and every output register. After reset, `out_valid` is 0 and `out_re`/`out_im` are 0 until new data has passed through both stages.
- R2: The pipeline advances only on clocks where `en` is 1. While `en` is 0 no counter moves and nothing is stored. `out_valid` falls two clocks after `en` falls, and the output data then holds. Gaps in `en` leave the produced stream unchanged.
- R3: For each frame x[0..N-1] the first stage forms s[n] = (x[n] + x[n+N/2]) >>> 1 and d[n] = (x[n] - x[n+N/2]) >>> 1, for n = 0..N/2-1. This is done separately on real and imaginary parts, with floor rounding and no rotation. It streams s[0..N/2-1] followed by d[0..N/2-1].
- R4: The second stage splits the first stage's stream into consecutive groups of N/2 samples u[0..N/2-1]. Within each group it forms (u[m] + u'[m+N/4]) >>> 1 and (u[m] - u'[m+N/4]) >>> 1, for m = 0..N/4-1.
- R5: u' equals u, except in the difference groups (every second group, counting the first group after reset as group 0). There the samples in the second quarter are replaced by -j times themselves, that is (re, im) becomes (im, -re). This is computed with one extra bit, so an input of -32768 is negated exactly.
- R6: Each output group carries the N/4 sums followed by the N/4 differences of the group it came from. The output stream therefore runs, per frame: sum group sums, sum group differences, difference group sums, difference group differences.
- R7: With `en` held high, the first valid output is registered by the (3N/4 + 2)-th rising edge counted from the edge that accepts sample 0 of the first frame. That is edge 14 for N = 16.
- R8: Full-scale inputs (-32768 and 32767 in any mix, including rotated -32768) yield the exact values of R3 to R5 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Input sample qualifier; the pipeline advances only when high |
| in_re | input | DW | Input sample, real part, two's complement |
| in_im | input | DW | Input sample, imaginary part, two's complement |
| out_valid | output | 1 | High when `out_re`/`out_im` hold a new second-stage result |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |

## Verification
Each stage adds one register, so a second-stage result leaves the block two clocks after the input that completes its butterfly. The first valid output follows 3N/4 + 2 edges after sample 0. The bench counts rising edges. It drives inputs and samples outputs on the falling edge, and compares the edge on which `out_valid` first rises with that count. Data is not tied to a fixed cycle. Every word presented while `out_valid` is high is collected in order and compared with a stream computed from R3 to R6. The same comparison therefore holds when `en` has gaps. Inside each gap the bench looks two edges after `en` fell and requires `out_valid` low and the data held.

// File: rtl/r22_pkg.sv
package r22_pkg;
  // Phase of a delay-feedback stage within its butterfly period.
  typedef enum logic {
    PH_FILL    = 1'b0,  // store new input, emit stored difference
    PH_COMBINE = 1'b1   // emit sum, store new difference
  } phase_e;
endpackage

// File: rtl/r22_delay_line.sv
module r22_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read-before-write on one address: a circular buffer of DEPTH entries.
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/r22_bfly_stage.sv
module r22_bfly_stage
  import r22_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LGN    = 4,
  parameter int DEPTH  = 8,
  parameter bit ROTATE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int HB = $clog2(DEPTH);    // counter bit that marks the second half
  localparam int AW = (HB > 0) ? HB : 1;
  localparam int EW = DW + 2;           // one bit for rotation, one for growth

  logic [LGN-1:0] cnt;
  logic           primed;
  phase_e         ph;
  logic           rot;

  assign ph = cnt[HB] ? PH_COMBINE : PH_FILL;

  generate
    if (ROTATE) begin : g_rot
      // -j applies to second-half inputs of every odd (difference) group
      assign rot = cnt[HB+1] & cnt[HB];
    end else begin : g_norot
      assign rot = 1'b0;
    end
  endgenerate

  // Feedback memory
  logic [AW-1:0]   addr;
  logic [2*DW-1:0] rd_word, wr_word;
  logic [DW-1:0]   rd_re, rd_im;

  assign addr = cnt[AW-1:0];
  assign {rd_re, rd_im} = rd_word;

  r22_delay_line #(.W(2*DW), .DEPTH(DEPTH)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .we   (in_vld),
    .addr (addr),
    .wdata(wr_word),
    .rdata(rd_word)
  );

  // Butterfly datapath
  logic signed [EW-1:0] a_re, a_im, x_re, x_im, b_re, b_im;
  logic signed [EW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic [DW-1:0]        sh_sum_re, sh_sum_im, sh_dif_re, sh_dif_im;

  always_comb begin
    a_re = {{2{rd_re[DW-1]}}, rd_re};
    a_im = {{2{rd_im[DW-1]}}, rd_im};
    x_re = {{2{in_re[DW-1]}}, in_re};
    x_im = {{2{in_im[DW-1]}}, in_im};
    if (rot) begin
      b_re = x_im;
      b_im = -x_re;
    end else begin
      b_re = x_re;
      b_im = x_im;
    end
    sum_re = a_re + b_re;
    sum_im = a_im + b_im;
    dif_re = a_re - b_re;
    dif_im = a_im - b_im;
    // Halving: the shifted value always fits in DW bits
    sh_sum_re = sum_re[DW:1];
    sh_sum_im = sum_im[DW:1];
    sh_dif_re = dif_re[DW:1];
    sh_dif_im = dif_im[DW:1];
  end

  assign wr_word = (ph == PH_COMBINE) ? {sh_dif_re, sh_dif_im} : {in_re, in_im};

  // Control and output register
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      primed  <= 1'b0;
      out_vld <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end else begin
      out_vld <= in_vld & primed;
      if (in_vld) begin
        cnt <= cnt + 1'b1;
        if (cnt[AW-1:0] == AW'(DEPTH - 1)) primed <= 1'b1;
        if (ph == PH_COMBINE) begin
          out_re <= sh_sum_re;
          out_im <= sh_sum_im;
        end else begin
          out_re <= rd_re;
          out_im <= rd_im;
        end
      end
    end
  end
endmodule

// File: rtl/r22_sdf_pair.sv
module r22_sdf_pair #(
  parameter int DW  = 16,
  parameter int LGN = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int N       = 1 << LGN;
  localparam int SPAN_A  = N / 2;
  localparam int SPAN_B  = N / 4;

  logic                 s1_vld;
  logic signed [DW-1:0] s1_re, s1_im;

  r22_bfly_stage #(.DW(DW), .LGN(LGN), .DEPTH(SPAN_A), .ROTATE(1'b0)) u_bu1 (
    .clk    (clk),
    .rst    (rst),
    .in_vld (en),
    .in_re  (in_re),
    .in_im  (in_im),
    .out_vld(s1_vld),
    .out_re (s1_re),
    .out_im (s1_im)
  );

  r22_bfly_stage #(.DW(DW), .LGN(LGN), .DEPTH(SPAN_B), .ROTATE(1'b1)) u_bu2 (
    .clk    (clk),
    .rst    (rst),
    .in_vld (s1_vld),
    .in_re  (s1_re),
    .in_im  (s1_im),
    .out_vld(out_valid),
    .out_re (out_re),
    .out_im (out_im)
  );
endmodule

// File: rtl/r22_sdf_pair_chk.sv
module r22_sdf_pair_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          s1_vld,
  input logic          out_valid,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im
);
  // R1: reset leaves no valid output behind it
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: the first stage produces nothing without an enabled input
  p_s1_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> $past(en));

  // R2: an output word always comes from a first-stage word one clock earlier
  p_out_needs_s1_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_vld));

  // R2: no first-stage word means the output data holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> ($stable(out_re) && $stable(out_im)));

  // R2: enable low stops the first stage on the next clock
  p_en_low_stops_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !s1_vld);
endmodule

bind r22_sdf_pair r22_sdf_pair_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .s1_vld   (s1_vld),
  .out_valid(out_valid),
  .out_re   (out_re),
  .out_im   (out_im)
);

// File: tb/tb_r22_sdf_pair.sv
module tb_r22_sdf_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int LGN = 4;
  localparam int N = 1 << LGN;
  localparam int H = N / 2;
  localparam int Q = N / 4;
  localparam int LAT = H + Q + 2;

  // Stimulus vectors: {re[31:16], im[15:0]}, two frames
  localparam logic [31:0] STIM [32] = '{
    32'h1000_0000, 32'h0800_F800, 32'h7FFF_0001, 32'hC000_4000,
    32'h0123_0456, 32'hFEDC_0BA9, 32'h0000_7FFF, 32'h8000_0000,
    32'h0400_0400, 32'hFC00_0400, 32'h0001_FFFF, 32'h3333_CCCD,
    32'h0A0A_F5F6, 32'h0000_0000, 32'h1111_2222, 32'hF00F_0FF0,
    32'h0003_0005, 32'hFFFD_0007, 32'h2000_E000, 32'h0FFF_F001,
    32'h5555_AAAA, 32'h0010_0020, 32'hFF00_00FF, 32'h0042_FFBE,
    32'h7000_9000, 32'h0100_0100, 32'hE123_1EDC, 32'h0077_0088,
    32'h8001_7FFF, 32'h0002_FFFE, 32'h1234_5678, 32'hABCD_0EF1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [DW-1:0] out_re, out_im;

  r22_sdf_pair #(.DW(DW), .LGN(LGN)) dut (
    .clk(clk), .rst(rst), .en(en), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int xr [64], xi [64];
  int er [64], ei [64];
  int gr [128], gi [128];
  int ngot = 0;
  int first_edge = -1;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  // Output collector
  always @(negedge clk) begin
    if (!rst && out_valid && ngot < 128) begin
      if (ngot == 0) first_edge = edges;
      gr[ngot] = int'(out_re);
      gi[ngot] = int'(out_im);
      ngot = ngot + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; in_re = '0; in_im = '0;
    @(negedge clk);
    @(negedge clk);
    ngot = 0; first_edge = -1;
    rst = 1'b0;
  endtask

  // Reference model built from the requirements
  task automatic build_expected(input int frames);
    int ur [64], ui [64];
    for (int f = 0; f < frames; f++) begin
      for (int n = 0; n < H; n++) begin
        ur[f*N+n]   = (xr[f*N+n] + xr[f*N+n+H]) >>> 1;
        ui[f*N+n]   = (xi[f*N+n] + xi[f*N+n+H]) >>> 1;
        ur[f*N+H+n] = (xr[f*N+n] - xr[f*N+n+H]) >>> 1;
        ui[f*N+H+n] = (xi[f*N+n] - xi[f*N+n+H]) >>> 1;
      end
    end
    for (int g = 0; g < 2*frames; g++) begin
      for (int p = 0; p < Q; p++) begin
        int ar, ai, br, bi, t;
        ar = ur[g*H+p];   ai = ui[g*H+p];
        br = ur[g*H+p+Q]; bi = ui[g*H+p+Q];
        if (g % 2 == 1) begin t = br; br = bi; bi = -t; end
        er[g*H+p]   = (ar + br) >>> 1;
        ei[g*H+p]   = (ai + bi) >>> 1;
        er[g*H+Q+p] = (ar - br) >>> 1;
        ei[g*H+Q+p] = (ai - bi) >>> 1;
      end
    end
  endtask

  task automatic run_frames(input int frames, input bit stall, input string req);
    int t0, cr, ci;
    t0 = -1;
    build_expected(frames);
    for (int i = 0; i < (frames + 1) * N; i++) begin
      @(negedge clk);
      en = 1'b1;
      in_re = (i < frames*N) ? DW'(xr[i]) : '0;
      in_im = (i < frames*N) ? DW'(xi[i]) : '0;
      if (i == 0) t0 = edges;
      if (stall && (i % 3 == 2)) begin
        @(negedge clk); en = 1'b0;
        @(negedge clk); cr = int'(out_re); ci = int'(out_im);
        @(negedge clk);
        check(!out_valid, "R2", "out_valid two clocks into gap", int'(out_valid), 0);
        check(int'(out_re) == cr && int'(out_im) == ci, "R2", "data held in gap",
              int'(out_re), cr);
      end
    end
    @(negedge clk); en = 1'b0;
    repeat (4) @(negedge clk);
    check(ngot >= frames*N, req, "output word count", ngot, frames*N);
    for (int k = 0; k < frames*N; k++) begin
      check(gr[k] == er[k], req, $sformatf("R3 R4 R5 R6 re[%0d]", k), gr[k], er[k]);
      check(gi[k] == ei[k], req, $sformatf("R3 R4 R5 R6 im[%0d]", k), gi[k], ei[k]);
    end
    if (!stall)
      check(first_edge == t0 + LAT, "R7", "first valid edge", first_edge - t0, LAT);
  endtask

  task automatic load_table();
    for (int i = 0; i < 32; i++) begin
      xr[i] = int'($signed(STIM[i][31:16]));
      xi[i] = int'($signed(STIM[i][15:0]));
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    apply_reset();
    @(negedge clk);
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_re == 0 && out_im == 0, "R1", "data after reset", int'(out_re), 0);

    // R3 R4 R5 R6 R7: table frames, continuous enable
    load_table();
    run_frames(2, 1'b0, "R6");

    // R2: same frames with enable gaps
    apply_reset();
    run_frames(2, 1'b1, "R2");

    // R8: full-scale values
    apply_reset();
    for (int i = 0; i < 2*N; i++) begin
      xr[i] = (i % 3 == 0) ? -32768 : ((i % 2 == 1) ? 32767 : -32768);
      xi[i] = (i % 5 < 2) ? 32767 : -32768;
    end
    run_frames(2, 1'b0, "R8");

    // R1: reset in the middle of a stream, then a fresh run
    apply_reset();
    load_table();
    for (int i = 0; i < N + 5; i++) begin
      @(negedge clk); en = 1'b1; in_re = DW'(xr[i % 32]); in_im = DW'(xi[i % 32]);
    end
    @(negedge clk); rst = 1'b1; en = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", "out_valid after mid-stream reset", int'(out_valid), 0);
    check(out_re == 0 && out_im == 0, "R1", "data after mid-stream reset",
          int'(out_re), 0);
    ngot = 0; first_edge = -1;
    rst = 1'b0;
    run_frames(2, 1'b0, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule